// File: doc/BRIEF.md
# Serial-Bus Register Slave for a Dual Digital Potentiometer

This block is the serial-bus front end of a two-channel digital potentiometer. It is an I2C slave that lets a host reach three volatile 8-bit registers: one tap position per wiper channel and one control register that holds a single run/shutdown bit. The block takes the raw SCL and SDA levels and three address strap inputs. It releases or pulls down SDA through an open-drain enable. It hands the wiper positions, a one-cycle load pulse per wiper and the run/shutdown level to the analog wiper control.

Both bus lines first pass through a two-flop synchronizer and then a clocked spike filter. Once the lines are clean, the block detects START, repeated START and STOP. It checks an identification byte, latches a register address and then either accepts data bytes or returns them. A write lands in the register on the ninth (acknowledge) clock of its data byte. Further data bytes in the same transfer step from the first wiper to the second. A read uses the usual combined form: a write header that sets the address, a repeated START, then a read header.

Top module: `dpot_i2c_slave`

## Requirements
- R1: The block answers only an identification byte whose upper seven bits are binary 1010 followed by the strap inputs (strap bit 2 first). Bit 0 is the direction, with 1 meaning read. A byte that does not match is not acknowledged, and the bytes after it are ignored until the next START.
- R2: Bytes are shifted most significant bit first. SDA is sampled on the rising edge of SCL. The slave changes its SDA drive only while SCL is low.
- R3: The slave pulls SDA low during the ninth clock for a matching identification byte, for a mapped register address and for each write data byte it accepts.
- R4: A data byte is stored on the ninth clock of that byte. The wiper being written shows a one-cycle load pulse at the same moment. Wiper outputs change at no other time.
- R5: Extra data bytes in one write go first to wiper 0 and then to wiper 1. A byte that arrives after wiper 1 has been written, or after the control register has been written, gets no acknowledge and is thrown away.
- R6: A read is a write header with an address byte, then a repeated START, then a header with the direction bit set. The slave then returns bytes starting at the addressed register, moving from wiper 0 to wiper 1 and then returning 00h. A NACK from the host ends the read.
- R7: After reset both wipers hold 80h and the control register reads 40h. The control register stores only bit 6, and every other bit reads 0. Bit 6 drives the run level output, where 1 means run.
- R8: The mapped addresses are 00h (wiper 0), 01h (wiper 1) and 10h (control). Any other address byte is not acknowledged, writes nothing and leaves the register pointer as it was.
- R9: A START seen while reset is asserted has no effect. A STOP at any point, even in the middle of a byte, ends the transfer without a write and leaves the slave idle.
- R10: A pulse on SCL or SDA shorter than FILT_LEN clock cycles after synchronization has no effect on the protocol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-up reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| strapAddr | input | 3 | Address strap levels, forming the low slave address bits |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiperPos | output | NUM_WIPERS x 8 | Tap position of each wiper |
| wiperLoad | output | NUM_WIPERS | One-cycle pulse when a wiper is written |
| potEnable | output | 1 | Run level from control bit 6 (0 = shutdown) |

## Verification
The bench builds the block with its default SYNC_STAGES of 2 and FILT_LEN of 6, and runs SCL at 40 system clocks per half period. That puts every legal edge well beyond the filter window. It also lets the bench inject two-cycle spikes that fall inside that window: a false SCL pulse during the low phase, and false START or STOP events on SDA during the high phase. Because the data and ack timing leaves about 10 clocks of margin around the filter latency, the bench can compare the wiper outputs with its model on every quiet low phase. It can also show that a STOP in the middle of a byte, an unmapped address and a spent pointer all leave the registers untouched.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_WIPERS = 2;
  localparam int CTRL_BIT   = 6;

  localparam logic [3:0]       DEV_TYPE    = 4'b1010;
  localparam logic [REG_W-1:0] CTRL_ADDR   = 8'h10;
  localparam logic [REG_W-1:0] WIPER_RESET = 8'h80;

  typedef enum logic [1:0] {
    SEL_W0   = 2'd0,
    SEL_W1   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } regSel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } phase_t;

  // strobes from the protocol control to the register datapath
  typedef struct packed {
    logic             wrEn;
    regSel_t          wrSel;
    logic [REG_W-1:0] wrData;
  } regStrobe_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       holdCnt;
  logic                   syncd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
  end

  assign syncd = syncChain[SYNC_STAGES-1];

  // a new level must persist FILT_LEN cycles before it is passed on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cleanOut <= 1'b1;
      holdCnt  <= '0;
    end else if (syncd == cleanOut) begin
      holdCnt <= '0;
    end else if (holdCnt == CNT_W'(FILT_LEN - 1)) begin
      cleanOut <= syncd;
      holdCnt  <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  p_filter_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cleanOut) |-> $past(syncd) == cleanOut)
    else $error("filtered line moved to a level not seen on the synchronizer");
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclF,
  input  logic             sdaF,
  input  logic [2:0]       strapAddr,
  input  logic [REG_W-1:0] rdData,
  output regSel_t          rdSel,
  output regStrobe_t       strobe,
  output logic             sdaPullLow
);
  phase_t           phase;
  regSel_t          ptr;
  logic [3:0]       bitCnt;
  logic [REG_W-1:0] rxShift, txShift;
  logic ackOn, txOn, rwRead, hostAck, sclQ, sdaQ;
  logic rise, fall, startEv, stopEv, ackDecide, wrEn;

  function automatic regSel_t decodeAddr(input logic [REG_W-1:0] a);
    if (a == 8'h00)           return SEL_W0;
    else if (a == 8'h01)      return SEL_W1;
    else if (a == CTRL_ADDR)  return SEL_CTRL;
    else                      return SEL_NONE;
  endfunction

  function automatic regSel_t nextSel(input regSel_t p);
    return (p == SEL_W0) ? SEL_W1 : SEL_NONE;
  endfunction

  assign rise    = sclF & ~sclQ;
  assign fall    = ~sclF & sclQ;
  assign startEv = sclF & sclQ & sdaQ & ~sdaF;
  assign stopEv  = sclF & sclQ & ~sdaQ & sdaF;
  assign wrEn    = rise && phase == ST_WDATA && bitCnt == 4'd8 && ackOn;

  always_comb begin
    ackDecide = 1'b0;
    case (phase)
      ST_ID:    ackDecide = rxShift[7:1] == {DEV_TYPE, strapAddr};
      ST_ADDR:  ackDecide = decodeAddr(rxShift) != SEL_NONE;
      ST_WDATA: ackDecide = ptr != SEL_NONE;
      default:  ackDecide = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;  ptr <= SEL_W0;   bitCnt <= '0;
      rxShift <= '0;     txShift <= '0;   ackOn <= 1'b0;
      txOn <= 1'b0;      rwRead <= 1'b0;  hostAck <= 1'b0;
      sclQ <= 1'b1;      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      if (startEv) begin
        phase <= ST_ID;  bitCnt <= '0;  ackOn <= 1'b0;  txOn <= 1'b0;
      end else if (stopEv) begin
        phase <= ST_IDLE; bitCnt <= '0; ackOn <= 1'b0;  txOn <= 1'b0;
      end else if (rise && phase != ST_IDLE) begin
        if (bitCnt < 4'd8) begin
          bitCnt <= bitCnt + 1'b1;
          if (phase != ST_RDATA) rxShift <= {rxShift[6:0], sdaF};
        end else begin
          bitCnt <= 4'd9;
          if (phase == ST_RDATA) hostAck <= ~sdaF;
          if (wrEn) ptr <= nextSel(ptr);
        end
      end else if (fall && phase != ST_IDLE) begin
        if (phase == ST_RDATA && bitCnt >= 4'd1 && bitCnt <= 4'd7)
          txShift <= {txShift[6:0], 1'b0};
        if (bitCnt == 4'd8) begin
          txOn <= 1'b0;
          if (phase != ST_RDATA) begin
            ackOn <= ackDecide;
            if (phase == ST_ID) rwRead <= rxShift[0];
            if (phase == ST_ADDR && ackDecide) ptr <= decodeAddr(rxShift);
          end
        end
        if (bitCnt == 4'd9) begin
          ackOn  <= 1'b0;
          bitCnt <= '0;
          case (phase)
            ST_ID: begin
              if (!ackOn) phase <= ST_IDLE;
              else if (rwRead) begin
                phase <= ST_RDATA; txOn <= 1'b1;
                txShift <= rdData; ptr <= nextSel(ptr);
              end else phase <= ST_ADDR;
            end
            ST_ADDR:  phase <= ackOn ? ST_WDATA : ST_IDLE;
            ST_WDATA: phase <= ackOn ? ST_WDATA : ST_IDLE;
            ST_RDATA: begin
              if (hostAck) begin
                txOn <= 1'b1; txShift <= rdData; ptr <= nextSel(ptr);
              end else phase <= ST_IDLE;
            end
            default: phase <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign rdSel         = ptr;
  assign strobe.wrEn   = wrEn;
  assign strobe.wrSel  = ptr;
  assign strobe.wrData = rxShift;
  assign sdaPullLow    = ackOn | (txOn & ~txShift[7]);

  p_sda_low_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclF)
    else $error("SDA drive changed while SCL high");
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    phase == ST_IDLE |-> !sdaPullLow)
    else $error("SDA held low while idle");
  p_commit_acked_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> sdaPullLow)
    else $error("register written on a clock that was not acknowledged");
  p_id_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_ID && ackOn) |-> rxShift[7:1] == {DEV_TYPE, strapAddr})
    else $error("acknowledged a foreign identification byte");
  p_no_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> strobe.wrSel != SEL_NONE)
    else $error("write strobe with no register selected");
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  regStrobe_t                           strobe,
  input  regSel_t                              rdSel,
  output logic [REG_W-1:0]                     rdData,
  output logic [NUM_WIPERS-1:0][REG_W-1:0]     wiperPos,
  output logic [NUM_WIPERS-1:0]                wiperLoad,
  output logic                                 potEnable
);
  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
    logic hit;
    assign hit = strobe.wrEn && strobe.wrSel == regSel_t'(2'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wiperPos[g]  <= WIPER_RESET;
        wiperLoad[g] <= 1'b0;
      end else begin
        wiperLoad[g] <= hit;
        if (hit) wiperPos[g] <= strobe.wrData;
      end
    end

    p_wiper_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(wiperPos[g]) |-> wiperLoad[g])
      else $error("wiper moved without a load pulse");
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) potEnable <= 1'b1;
    else if (strobe.wrEn && strobe.wrSel == SEL_CTRL)
      potEnable <= strobe.wrData[CTRL_BIT];
  end

  always_comb begin
    case (rdSel)
      SEL_W0:   rdData = wiperPos[0];
      SEL_W1:   rdData = wiperPos[1];
      SEL_CTRL: rdData = {1'b0, potEnable, 6'b0};
      default:  rdData = '0;
    endcase
  end

  p_ctrl_apply_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrSel == SEL_CTRL) |=> potEnable == $past(strobe.wrData[CTRL_BIT]))
    else $error("control write did not take bit 6");
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
  import dpot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sclIn,
  input  logic                             sdaIn,
  input  logic [2:0]                       strapAddr,
  output logic                             sdaPullLow,
  output logic [NUM_WIPERS-1:0][REG_W-1:0] wiperPos,
  output logic [NUM_WIPERS-1:0]            wiperLoad,
  output logic                             potEnable
);
  logic [1:0]       rawLines, cleanLines;
  regStrobe_t       strobe;
  regSel_t          rdSel;
  logic [REG_W-1:0] rdData;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(cleanLines[g]));
  end

  dpot_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclF(cleanLines[0]), .sdaF(cleanLines[1]),
    .strapAddr(strapAddr), .rdData(rdData), .rdSel(rdSel),
    .strobe(strobe), .sdaPullLow(sdaPullLow));

  dpot_regs i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .rdData(rdData),
    .wiperPos(wiperPos), .wiperLoad(wiperLoad), .potEnable(potEnable));
endmodule

// File: tb/test_dpot_i2c_slave.sv
module test_dpot_i2c_slave;
  localparam int HALF = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, sclDrv = 1'b1, mLow = 1'b0, sclGl = 1'b0, sdaGl = 1'b0;
  logic [2:0] strap = 3'b101;
  logic dutLow, sdaBus, potEnable;
  logic [1:0][7:0] wiperPos;
  logic [1:0] wiperLoad;

  assign sdaBus = ~(mLow | dutLow);

  dpot_i2c_slave i_dpot_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv ^ sclGl), .sdaIn(sdaBus ^ sdaGl),
    .strapAddr(strap), .sdaPullLow(dutLow), .wiperPos(wiperPos),
    .wiperLoad(wiperLoad), .potEnable(potEnable));

  int total = 0, bad = 0, cyc = 0, fallCyc = 0;
  bit busy = 1'b0;
  int expReg [3] = '{8'h80, 8'h80, 8'h40};
  int ptrM = 0;
  int expLoad [2] = '{0, 0};
  int seenLoad [2] = '{0, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 2; i++) if (rstN && wiperLoad[i]) seenLoad[i] <= seenLoad[i] + 1;
  end

  // reference comparison on every quiet clock
  always @(negedge clk) begin
    if (rstN && (!busy || (sclDrv == 1'b0 && cyc - fallCyc > 16))) begin
      check(wiperPos[0] == expReg[0][7:0], "R4 wiper0 vs model", wiperPos[0], expReg[0]);
      check(wiperPos[1] == expReg[1][7:0], "R4 wiper1 vs model", wiperPos[1], expReg[1]);
      check(potEnable == expReg[2][6], "R7 run level vs model", potEnable, expReg[2][6]);
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitCycle(input bit b, input bit glitch, output bit s1, output bit s2);
    @(negedge clk); sclDrv = 1'b0; fallCyc = cyc;
    ticks(4); if (glitch) sclGl = 1'b1;
    ticks(2); sclGl = 1'b0;
    ticks(13); mLow = ~b;
    ticks(20); sclDrv = 1'b1;
    ticks(20); s1 = sdaBus;
    ticks(4); if (glitch) sdaGl = 1'b1;
    ticks(2); sdaGl = 1'b0;
    ticks(12); s2 = sdaBus;
    ticks(1);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit glitch, output bit acked);
    bit s1, s2;
    for (int i = 7; i >= 0; i--) bitCycle(v[i], glitch, s1, s2);
    bitCycle(1'b1, glitch, s1, s2);
    acked = !s1;
  endtask

  task automatic readByte(input bit nack, output logic [7:0] v, output bit stable);
    bit s1, s2;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, 1'b0, s1, s2);
      v[i] = s1;
      if (s1 != s2) stable = 1'b0;
    end
    bitCycle(nack, 1'b0, s1, s2);
  endtask

  task automatic startCond();
    mLow = 1'b0; ticks(HALF / 2);
    mLow = 1'b1; ticks(HALF / 2);
  endtask

  task automatic repStart();
    @(negedge clk); sclDrv = 1'b0; fallCyc = cyc;
    ticks(HALF / 2); mLow = 1'b0;
    ticks(HALF / 2); sclDrv = 1'b1;
    startCond();
  endtask

  task automatic stopCond();
    @(negedge clk); sclDrv = 1'b0; fallCyc = cyc;
    ticks(HALF / 2); mLow = 1'b1;
    ticks(HALF / 2); sclDrv = 1'b1;
    ticks(HALF / 2); mLow = 1'b0;
    ticks(HALF);
  endtask

  function automatic int decodeM(input logic [7:0] a);
    if (a == 8'h00) return 0;
    if (a == 8'h01) return 1;
    if (a == 8'h10) return 2;
    return 3;
  endfunction

  function automatic int nextM(input int p);
    return (p == 0) ? 1 : 3;
  endfunction

  task automatic doWrite(input logic [2:0] idS, input logic [7:0] addr, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input bit glitch);
    bit ack;
    logic [7:0] dv [3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    busy = 1'b1;
    startCond();
    sendByte({4'b1010, idS, 1'b0}, glitch, ack);
    check(ack == (idS == strap), "R1 R3 identification ack", ack, idS == strap);
    if (!ack) begin
      sendByte(addr, 1'b0, ack);
      check(!ack, "R1 address ignored after foreign id", ack, 0);
      sendByte(d0, 1'b0, ack);
      check(!ack, "R1 data ignored after foreign id", ack, 0);
    end else begin
      sendByte(addr, glitch, ack);
      check(ack == (decodeM(addr) != 3), "R8 R3 address ack", ack, decodeM(addr) != 3);
      if (ack) begin
        ptrM = decodeM(addr);
        for (int k = 0; k < n; k++) begin
          sendByte(dv[k], glitch, ack);
          check(ack == (ptrM != 3), "R5 R3 data ack", ack, ptrM != 3);
          if (!ack) break;
          if (ptrM < 2) begin
            expReg[ptrM] = dv[k];
            expLoad[ptrM]++;
          end else expReg[2] = dv[k] & 8'h40;
          ptrM = nextM(ptrM);
        end
      end
    end
    stopCond();
    busy = 1'b0;
    ticks(4);
    check(seenLoad[0] == expLoad[0], "R4 wiper0 load pulses", seenLoad[0], expLoad[0]);
    check(seenLoad[1] == expLoad[1], "R4 wiper1 load pulses", seenLoad[1], expLoad[1]);
  endtask

  task automatic doRead(input logic [7:0] addr, input int n);
    bit ack, st;
    logic [7:0] v;
    int e;
    busy = 1'b1;
    startCond();
    sendByte({4'b1010, strap, 1'b0}, 1'b0, ack);
    check(ack, "R3 read header ack", ack, 1);
    sendByte(addr, 1'b0, ack);
    check(ack, "R6 R3 read address ack", ack, 1);
    ptrM = decodeM(addr);
    repStart();
    sendByte({4'b1010, strap, 1'b1}, 1'b0, ack);
    check(ack, "R6 read identification ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      readByte(k == n - 1, v, st);
      e = (ptrM < 3) ? expReg[ptrM] : 0;
      ptrM = nextM(ptrM);
      check(v == e[7:0], "R6 R2 read data", v, e);
      check(st, "R2 SDA steady while SCL high", st, 1);
    end
    stopCond();
    busy = 1'b0;
    ticks(4);
  endtask

  task automatic finish();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1..all actual=timeout expected=finished");
    finish();
  end

  initial begin
    bit ack, s1, s2;
    ticks(5);
    // R9: traffic while reset is held
    startCond();
    sendByte({4'b1010, strap, 1'b0}, 1'b0, ack);
    check(!ack, "R9 START ignored during reset", ack, 0);
    ticks(10);
    rstN = 1'b1;
    ticks(20);
    check(wiperPos[0] == 8'h80, "R7 wiper0 reset", wiperPos[0], 8'h80);
    check(wiperPos[1] == 8'h80, "R7 wiper1 reset", wiperPos[1], 8'h80);
    check(potEnable == 1'b1, "R7 run level reset", potEnable, 1);
    check(sdaBus == 1'b1, "R3 SDA released at reset", sdaBus, 1);
    doRead(8'h10, 1);                                   // R7 reads 40h
    doWrite(strap, 8'h00, 1, 8'h3C, 8'h00, 8'h00, 1'b0); // R4
    doWrite(strap, 8'h01, 1, 8'hA5, 8'h00, 8'h00, 1'b0); // R4
    doWrite(strap, 8'h00, 3, 8'h11, 8'h22, 8'h33, 1'b0); // R5 third byte NACK
    doRead(8'h00, 3);                                   // R6 11,22,00
    doWrite(strap, 8'h10, 2, 8'h00, 8'h77, 8'h00, 1'b0); // R5 R7 shutdown
    doRead(8'h10, 1);
    doWrite(strap, 8'h10, 1, 8'hFF, 8'h00, 8'h00, 1'b0); // R7 only bit 6 kept
    doRead(8'h10, 1);
    doWrite(3'b001, 8'h00, 1, 8'h99, 8'h00, 8'h00, 1'b0); // R1 foreign id
    doWrite(strap, 8'h05, 1, 8'h99, 8'h00, 8'h00, 1'b0);  // R8
    doWrite(strap, 8'h02, 1, 8'h99, 8'h00, 8'h00, 1'b0);  // R8
    doRead(8'h01, 1);                                   // R8 pointer logic intact
    doWrite(strap, 8'h00, 2, 8'h5A, 8'hC3, 8'h00, 1'b1); // R10 spikes everywhere
    doRead(8'h00, 2);
    // R9: STOP in the middle of a data byte
    busy = 1'b1;
    startCond();
    sendByte({4'b1010, strap, 1'b0}, 1'b0, ack);
    sendByte(8'h00, 1'b0, ack);
    for (int i = 0; i < 4; i++) bitCycle(1'b0, 1'b0, s1, s2);
    stopCond();
    busy = 1'b0;
    ticks(4);
    check(wiperPos[0] == 8'h5A, "R9 aborted byte not stored", wiperPos[0], 8'h5A);
    check(seenLoad[0] == expLoad[0], "R9 no load pulse on abort", seenLoad[0], expLoad[0]);
    doWrite(strap, 8'h00, 1, 8'h07, 8'h00, 8'h00, 1'b0); // R9 idle and ready
    strap = 3'b010;
    ticks(10);
    doWrite(3'b101, 8'h01, 1, 8'hEE, 8'h00, 8'h00, 1'b0); // R1 old strap refused
    doWrite(strap, 8'h01, 1, 8'h0F, 8'h00, 8'h00, 1'b0);  // R1 new strap accepted
    doRead(8'h00, 2);
    finish();
  end
endmodule